// File: doc/BRIEF.md
# Serial 1011 Pattern Detector

This block watches a one-bit serial input that is not aligned to the local clock, and raises a flag each time the bit sequence 1, 0, 1, 1 is completed on that input. The input is first retimed through a two-stage flip-flop synchronizer. A four-state machine then tracks how much of the pattern has arrived. A Mealy detection term, taken from the state together with the retimed bit, is captured in an output register that drives the flag port.

The machine follows a fixed transition table. That table does not allow overlap the way a textbook overlapping detector would. A second 1 while waiting for a 0 abandons the attempt. Every completed match also sends the machine back to idle. The caller samples one serial bit per clock and reads `found` as a single-cycle pulse. The pulse arrives three clocks after the bit that completed the pattern was first sampled.

Top module: `seq1011_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the synchronizer stages, the state and `found` are all cleared. The state is cleared to idle (encoding 2'b00), and `found` reads 0 in the cycle after that edge.
- R2: When the retimed bit stream completes 1, 0, 1, 1 along the transitions below, `found` is 1 for that detection.
- R3: `found` stays high for exactly one clock per detection and never for two consecutive clocks.
- R4: From the "seen 1" state (2'b01), a 1 returns the machine to idle, so the stream 1,1,0,1,1 yields no detection.
- R5: From the "seen 101" state (2'b11), the machine returns to idle for either input value. After 1,0,1,1 the stream 0,1,1 yields no further detection, while 1,0,1,1 yields one more.
- R6: From the "seen 10" state (2'b10), a 0 returns the machine to idle, so 1,0,0,1,0,1,1 yields exactly one detection.
- R7: From idle a 0 stays in idle and a 1 moves to "seen 1" (2'b01). From "seen 1" a 0 moves to "seen 10" (2'b10). From "seen 10" a 1 moves to "seen 101" (2'b11).
- R8: A bit present on `ser_in` at rising edge k shows its effect on `found` right after edge k+2. This is three sampling edges in all: two synchronizer stages and the output register.
- R9: Reset is synchronous. Asserting it in the middle of a partial pattern discards that progress, so 1,0,1, then reset, then 1 gives no detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Asynchronous serial data bit |
| found | output | 1 | Registered one-cycle pulse on a completed 1011 match |

## Verification
The assertions assume that `ser_in` holds one value across each rising edge, so that the value the checker looks back at is the value the synchronizer captured. The bench meets this by changing `ser_in` only one nanosecond after each rising edge, never near the next one. The look-back checks also assume that six clean edges have passed since reset, and the checker counts these itself. The random phase mixes biased bits with rare reset pulses, so the partial patterns cover all three abandon paths.

// File: rtl/seq1011_pkg.sv
package seq1011_pkg;

    // Progress of the pattern match; binary encoding is fixed.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_GOT1   = 2'b01,
        ST_GOT10  = 2'b10,
        ST_GOT101 = 2'b11
    } det_state_e;

    typedef struct packed {
        det_state_e state;
    } fsm_regs_t;

    typedef struct packed {
        logic flag;
    } out_regs_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        if (rst) begin
            sync_d.chain = '0;
        end else begin
            sync_d.chain[0] = async_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_d.chain[i] = sync_q.chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        sync_q <= sync_d;
    end

    assign sync_out = sync_q.chain[LAST];

endmodule

// File: rtl/det_fsm.sv
module det_fsm
    import seq1011_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    output logic       hit,
    output det_state_e state_o
);
    fsm_regs_t fsm_d, fsm_q;
    logic      hit_d;

    always_comb begin
        fsm_d = fsm_q;
        hit_d = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE:   fsm_d.state = bit_in ? ST_GOT1 : ST_IDLE;
            ST_GOT1:   fsm_d.state = bit_in ? ST_IDLE : ST_GOT10;
            ST_GOT10:  fsm_d.state = bit_in ? ST_GOT101 : ST_IDLE;
            ST_GOT101: begin
                fsm_d.state = ST_IDLE;
                hit_d       = bit_in;
            end
            default:   fsm_d.state = ST_IDLE;
        endcase
        if (rst) begin
            fsm_d.state = ST_IDLE;
            hit_d       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign hit     = hit_d;
    assign state_o = fsm_q.state;

endmodule

// File: rtl/seq1011_detector.sv
module seq1011_detector
    import seq1011_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    output logic found
);
    logic       bit_sync_w;
    logic       hit_w;
    det_state_e cur_state;
    out_regs_t  out_d, out_q;

    bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ser_in),
        .sync_out (bit_sync_w)
    );

    det_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_sync_w),
        .hit     (hit_w),
        .state_o (cur_state)
    );

    always_comb begin
        out_d      = out_q;
        out_d.flag = rst ? 1'b0 : hit_w;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign found = out_q.flag;

endmodule

// File: rtl/seq1011_checker.sv
module seq1011_checker (
    input logic       clk,
    input logic       rst,
    input logic       ser_in,
    input logic       found,
    input logic [1:0] state
);
    logic [2:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)              age_q <= 3'd0;
        else if (age_q != 3'd7) age_q <= age_q + 3'd1;
    end

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!found && state == 2'b00)); // R1

    AST_MATCH_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (found && age_q >= 3'd6) |->
        ($past(ser_in,3) && $past(ser_in,4) && !$past(ser_in,5) && $past(ser_in,6))); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        found |=> !found); // R3

    AST_IDLE_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        found |-> state == 2'b00); // R5

    AST_ONE_FROM_SEEN1: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01) |=> (state == 2'b00 || state == 2'b10)); // R4

endmodule

bind seq1011_detector seq1011_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .found  (found),
    .state  (cur_state)
);

// File: tb/tb_seq1011_detector.sv
`timescale 1ns/1ps
module tb_seq1011_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic found;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;

    // bench reference: pipeline of two retimed bits plus state
    int m_state = 0;
    logic h1 = 1'b0, h2 = 1'b0;
    logic m_found = 1'b0;

    always #2.5 clk = ~clk;

    seq1011_detector dut (.clk(clk), .rst(rst), .ser_in(ser_in), .found(found));

    function automatic int ref_next(int s, logic b);
        case (s)
            0: return b ? 1 : 0;
            1: return b ? 0 : 2;
            2: return b ? 3 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic ref_hit(int s, logic b);
        return (s == 3) && b;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: found=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(logic b, string tag);
        ser_in = b;
        @(posedge clk); #1;
        m_found = ref_hit(m_state, h2);
        m_state = ref_next(m_state, h2);
        h2 = h1;
        h1 = b;
        if (found === 1'b1) pulses++;
        check(tag, found, m_found);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        ser_in = 1'b0;
        @(posedge clk); #1;
        m_state = 0; h1 = 1'b0; h2 = 1'b0; m_found = 1'b0;
        check(tag, found, 1'b0);
        rst = 1'b0;
    endtask

    task automatic run_seq(logic [15:0] bits, int len, int exp_pulses, string tag);
        pulses = 0;
        for (int i = len - 1; i >= 0; i--) drive(bits[i], tag);
        for (int i = 0; i < 3; i++) drive(1'b0, tag);
        n_checks++;
        if (pulses != exp_pulses) begin
            n_fail++;
            $display("FAIL %s: pulses=%0d expected=%0d", tag, pulses, exp_pulses);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int dummy;
        dummy = $urandom(32'h1011);
        @(posedge clk); #1;
        do_reset("R1");
        do_reset("R1");
        run_seq(16'b011, 3, 0, "R1");

        // latency: last 1 sampled, pulse appears after the third edge (R8)
        drive(1'b1, "R8"); drive(1'b0, "R8"); drive(1'b1, "R8"); drive(1'b1, "R8");
        check("R8", found, 1'b0);
        drive(1'b0, "R8"); check("R8", found, 1'b0);
        drive(1'b0, "R8"); check("R8", found, 1'b1);
        drive(1'b0, "R3"); check("R3", found, 1'b0);

        run_seq(16'b1011, 4, 1, "R2");
        run_seq(16'b11011, 5, 0, "R4");
        run_seq(16'b1011011, 7, 1, "R5");
        run_seq(16'b10111011, 8, 2, "R5");
        run_seq(16'b1001011, 7, 1, "R6");
        run_seq(16'b0001011, 7, 1, "R7");

        // mid-pattern reset (R9)
        pulses = 0;
        drive(1'b1, "R9"); drive(1'b0, "R9"); drive(1'b1, "R9");
        do_reset("R9");
        drive(1'b1, "R9");
        for (int i = 0; i < 4; i++) drive(1'b0, "R9");
        n_checks++;
        if (pulses != 0) begin
            n_fail++;
            $display("FAIL R9: pulses=%0d expected=0", pulses);
        end

        // random stream with rare resets
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 200) == 0) do_reset("R1");
            else drive((($urandom % 8) < 5) ? 1'b1 : 1'b0, "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule